// File: doc/BRIEF.md
# Corrected Quadrature LO Downconverter

This block shifts a digital-IF complex sample stream down to zero IF. A phase accumulator, stepped once per accepted input sample by a programmable frequency word, addresses a cosine lookup table. The same table, read a quarter turn behind, supplies the sine. The sine branch of the oscillator is the Q-path LO, and it carries two corrections that cancel the analog gain and phase imbalance between the I and Q paths at one baseband frequency. The phase correction is a signed offset on its table address. The gain correction is an unsigned fixed-point scale factor.

The corrected oscillator feeds a balanced complex mixer built from four real multipliers. It rotates each input pair (I, Q) by the negative LO phase, which places the wanted channel at DC and keeps its image apart. Results are rounded, clipped to the input width and emitted through a fixed three-stage pipeline that accepts one sample per clock. Decimation before the mixer and channel filtering after it belong to neighbouring blocks.

Top module: `quad_lo_mixer`

## Requirements
- R1: A 24-bit phase register resets to 0. On each clock with `in_valid` high, the sample uses the current phase, and the phase then becomes (phase + `freq_word`) mod 2^24. With `in_valid` low the phase does not move.
- R2: The cosine term c is table entry k = phase[23:16], where entry k = round-half-away(2047·cos(2πk/256)).
- R3: The Q-path LO raw term s is table entry (k + `lo_phase_adj` − 64) mod 256, with `lo_phase_adj` read as signed 8-bit. Zero adjustment therefore gives 2047·sin(2πk/256).
- R4: The corrected term is sc = (s·g + 1024) >>> 11, where g is the unsigned 12-bit `lo_gain` in 1.11 format. The value 2048 means unity and 0 removes the sine branch.
- R5: The mixer forms out_i = (I·c + Q·sc + 1024) >>> 11 and out_q = (Q·c − I·sc + 1024) >>> 11. Both use full-precision products and arithmetic shifts.
- R6: Each mixer result is clipped to the range −32768 to 32767 before it is output.
- R7: `out_valid` and the matching results appear after the third rising edge, counting the edge that captures the sample. Back-to-back samples give back-to-back results.
- R8: Between results `out_valid` is low and `out_i`/`out_q` hold the last result.
- R9: While `rst_n` is low, `out_valid`, `out_i` and `out_q` are 0 and the phase returns to 0.
- R10: `lo_phase_adj`, `lo_gain` and `freq_word` take effect only at the capture edge. A change in the following cycle does not alter the result of a sample already captured, nor the phase step it caused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe; also steps the phase |
| in_i | input | 16 | In-phase input, two's complement |
| in_q | input | 16 | Quadrature input, two's complement |
| freq_word | input | 24 | Phase increment per accepted sample |
| lo_phase_adj | input | 8 | Signed table-address offset of the Q-path LO |
| lo_gain | input | 12 | Unsigned 1.11 scale of the Q-path LO |
| out_valid | output | 1 | Result strobe |
| out_i | output | 16 | Zero-IF in-phase result |
| out_q | output | 16 | Zero-IF quadrature result |

## Verification
The hardest case to reach from the ports is a clipped output. Clipping needs a large input, a large gain and a known oscillator phase all at once, but the phase is the hidden sum of every earlier increment. The stimulus resets the block in the middle of the run and holds the frequency word at zero, so the table address stays at 0. It then selects a 45-degree Q-path offset and near-maximum gain, which drives the in-phase sum past full scale in both directions. A second awkward case is a change to the settings in the cycle right after capture. The bench makes that change and checks that the result in flight, and the next phase, still reflect the values that were present at capture.

// File: rtl/lo_pkg.sv
package lo_pkg;

    localparam int PHASE_W_DEF   = 24;
    localparam int ADDR_W_DEF    = 8;
    localparam int ROM_W_DEF     = 12;
    localparam int DATA_W_DEF    = 16;
    localparam int GAIN_W_DEF    = 12;
    localparam int GAIN_FRAC_DEF = 11;

    localparam real TWO_PI = 2.0 * 3.14159265358979323846;

    // Rounded cosine sample, half away from zero, for table index k.
    function automatic int cos_value(input int k, input int addr_w, input int amp);
        real v;
        v = $cos(TWO_PI * real'(k) / real'(1 << addr_w)) * real'(amp);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return $rtoi(v - 0.5);
    endfunction

endpackage

// File: rtl/lo_cos_rom.sv
module lo_cos_rom #(
    parameter int ADDR_W = lo_pkg::ADDR_W_DEF,
    parameter int ROM_W  = lo_pkg::ROM_W_DEF
) (
    input  logic [ADDR_W-1:0]       addr_a,
    input  logic [ADDR_W-1:0]       addr_b,
    output logic signed [ROM_W-1:0] data_a,
    output logic signed [ROM_W-1:0] data_b
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int AMP   = (1 << (ROM_W - 1)) - 1;

    logic signed [ROM_W-1:0] tbl_w [DEPTH];

    // One full cosine period; both LO branches read the same table.
    generate
        for (genvar k = 0; k < DEPTH; k++) begin : g_entry
            assign tbl_w[k] = ROM_W'(lo_pkg::cos_value(k, ADDR_W, AMP));
        end
    endgenerate

    assign data_a = tbl_w[addr_a];
    assign data_b = tbl_w[addr_b];
endmodule

// File: rtl/lo_phase_acc.sv
module lo_phase_acc #(
    parameter int PHASE_W = lo_pkg::PHASE_W_DEF,
    parameter int ADDR_W  = lo_pkg::ADDR_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step,
    input  logic [PHASE_W-1:0] freq_word,
    output logic [ADDR_W-1:0]  addr
);
    typedef struct packed {
        logic [PHASE_W-1:0] phase;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (step) begin
            acc_d.phase = acc_q.phase + freq_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign addr = acc_q.phase[PHASE_W-1 -: ADDR_W];
endmodule

// File: rtl/lo_corr_mix.sv
module lo_corr_mix #(
    parameter int DATA_W    = lo_pkg::DATA_W_DEF,
    parameter int ROM_W     = lo_pkg::ROM_W_DEF,
    parameter int GAIN_W    = lo_pkg::GAIN_W_DEF,
    parameter int GAIN_FRAC = lo_pkg::GAIN_FRAC_DEF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     s1_valid,
    input  logic signed [DATA_W-1:0] s1_i,
    input  logic signed [DATA_W-1:0] s1_q,
    input  logic signed [ROM_W-1:0]  s1_c,
    input  logic signed [ROM_W-1:0]  s1_s,
    input  logic [GAIN_W-1:0]        s1_gain,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_i,
    output logic signed [DATA_W-1:0] out_q
);
    localparam int SC_W   = ROM_W + GAIN_W - GAIN_FRAC;
    localparam int GP_W   = ROM_W + GAIN_W + 1;
    localparam int SUM_W  = DATA_W + SC_W + 2;
    localparam int MIX_SH = ROM_W - 1;

    localparam logic signed [GP_W-1:0]  RND_G = GP_W'(1) << (GAIN_FRAC - 1);
    localparam logic signed [SUM_W-1:0] RND_M = SUM_W'(1) << (MIX_SH - 1);
    localparam logic signed [SUM_W-1:0] MAXV  = SUM_W'((1 << (DATA_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] MINV  = -MAXV - SUM_W'(1);

    typedef struct packed {
        logic                     valid;
        logic signed [DATA_W-1:0] i;
        logic signed [DATA_W-1:0] q;
        logic signed [ROM_W-1:0]  c;
        logic signed [SC_W-1:0]   sc;
    } s2_t;

    typedef struct packed {
        logic                     valid;
        logic signed [DATA_W-1:0] oi;
        logic signed [DATA_W-1:0] oq;
    } s3_t;

    s2_t s2_d, s2_q;
    s3_t s3_d, s3_q;

    function automatic logic signed [DATA_W-1:0] clip(input logic signed [SUM_W-1:0] v);
        if (v > MAXV) return DATA_W'(MAXV);
        if (v < MINV) return DATA_W'(MINV);
        return DATA_W'(v);
    endfunction

    // Stage 2: gain correction of the Q-path LO term.
    always_comb begin
        logic signed [GP_W-1:0] s_x;
        logic signed [GP_W-1:0] g_x;
        logic signed [GP_W-1:0] prod;
        logic signed [GP_W-1:0] scaled;
        s2_d       = s2_q;
        s2_d.valid = s1_valid;
        s_x        = GP_W'(s1_s);
        g_x        = GP_W'({1'b0, s1_gain});
        prod       = s_x * g_x;
        scaled     = (prod + RND_G) >>> GAIN_FRAC;
        if (s1_valid) begin
            s2_d.i  = s1_i;
            s2_d.q  = s1_q;
            s2_d.c  = s1_c;
            s2_d.sc = SC_W'(scaled);
        end
    end

    // Stage 3: four real products, rounding and clipping.
    always_comb begin
        logic signed [SUM_W-1:0] xi, xq, xc, xs;
        logic signed [SUM_W-1:0] acc_i, acc_q;
        logic signed [SUM_W-1:0] rnd_i, rnd_q;
        s3_d       = s3_q;
        s3_d.valid = s2_q.valid;
        xi         = SUM_W'(s2_q.i);
        xq         = SUM_W'(s2_q.q);
        xc         = SUM_W'(s2_q.c);
        xs         = SUM_W'(s2_q.sc);
        acc_i      = xi * xc + xq * xs;
        acc_q      = xq * xc - xi * xs;
        rnd_i      = (acc_i + RND_M) >>> MIX_SH;
        rnd_q      = (acc_q + RND_M) >>> MIX_SH;
        if (s2_q.valid) begin
            s3_d.oi = clip(rnd_i);
            s3_d.oq = clip(rnd_q);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s2_q <= s2_d;
            s3_q <= s3_d;
        end
    end

    assign out_valid = s3_q.valid;
    assign out_i     = s3_q.oi;
    assign out_q     = s3_q.oq;
endmodule

// File: rtl/quad_lo_mixer.sv
module quad_lo_mixer #(
    parameter int PHASE_W   = lo_pkg::PHASE_W_DEF,
    parameter int ADDR_W    = lo_pkg::ADDR_W_DEF,
    parameter int ROM_W     = lo_pkg::ROM_W_DEF,
    parameter int DATA_W    = lo_pkg::DATA_W_DEF,
    parameter int GAIN_W    = lo_pkg::GAIN_W_DEF,
    parameter int GAIN_FRAC = lo_pkg::GAIN_FRAC_DEF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_i,
    input  logic signed [DATA_W-1:0] in_q,
    input  logic [PHASE_W-1:0]       freq_word,
    input  logic signed [ADDR_W-1:0] lo_phase_adj,
    input  logic [GAIN_W-1:0]        lo_gain,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_i,
    output logic signed [DATA_W-1:0] out_q
);
    localparam logic [ADDR_W-1:0] QUARTER = ADDR_W'(1) << (ADDR_W - 2);

    typedef struct packed {
        logic                     valid;
        logic signed [DATA_W-1:0] i;
        logic signed [DATA_W-1:0] q;
        logic signed [ROM_W-1:0]  c;
        logic signed [ROM_W-1:0]  s;
        logic [GAIN_W-1:0]        gain;
    } s1_t;

    s1_t s1_d, s1_q;

    logic [ADDR_W-1:0]       cos_addr;
    logic [ADDR_W-1:0]       sin_addr;
    logic signed [ROM_W-1:0] rom_cos;
    logic signed [ROM_W-1:0] rom_sin;

    lo_phase_acc #(
        .PHASE_W (PHASE_W),
        .ADDR_W  (ADDR_W)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (in_valid),
        .freq_word (freq_word),
        .addr      (cos_addr)
    );

    // Quarter turn back gives sine; the adjustment shifts only the Q-path LO.
    assign sin_addr = cos_addr + $unsigned(lo_phase_adj) - QUARTER;

    lo_cos_rom #(
        .ADDR_W (ADDR_W),
        .ROM_W  (ROM_W)
    ) u_rom (
        .addr_a (cos_addr),
        .addr_b (sin_addr),
        .data_a (rom_cos),
        .data_b (rom_sin)
    );

    // Stage 1: capture sample, both LO terms and the gain setting.
    always_comb begin
        s1_d       = s1_q;
        s1_d.valid = in_valid;
        if (in_valid) begin
            s1_d.i    = in_i;
            s1_d.q    = in_q;
            s1_d.c    = rom_cos;
            s1_d.s    = rom_sin;
            s1_d.gain = lo_gain;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s1_q <= '0;
        else        s1_q <= s1_d;
    end

    lo_corr_mix #(
        .DATA_W    (DATA_W),
        .ROM_W     (ROM_W),
        .GAIN_W    (GAIN_W),
        .GAIN_FRAC (GAIN_FRAC)
    ) u_mix (
        .clk       (clk),
        .rst_n     (rst_n),
        .s1_valid  (s1_q.valid),
        .s1_i      (s1_q.i),
        .s1_q      (s1_q.q),
        .s1_c      (s1_q.c),
        .s1_s      (s1_q.s),
        .s1_gain   (s1_q.gain),
        .out_valid (out_valid),
        .out_i     (out_i),
        .out_q     (out_q)
    );
endmodule

// File: rtl/lo_mix_checker.sv
module lo_mix_checker #(
    parameter int DATA_W  = lo_pkg::DATA_W_DEF,
    parameter int PHASE_W = lo_pkg::PHASE_W_DEF
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic signed [DATA_W-1:0] in_i,
    input logic signed [DATA_W-1:0] in_q,
    input logic [PHASE_W-1:0]       freq_word,
    input logic [PHASE_W-1:0]       phase,
    input logic                     out_valid,
    input logic signed [DATA_W-1:0] out_i,
    input logic signed [DATA_W-1:0] out_q
);
    logic [2:0] v_sr;
    logic [2:0] z_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_sr <= '0;
            z_sr <= '0;
        end else begin
            v_sr <= {v_sr[1:0], in_valid};
            z_sr <= {z_sr[1:0], in_valid && (in_i == '0) && (in_q == '0)};
        end
    end

    p_phase_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(phase));

    p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> phase == PHASE_W'($past(phase) + $past(freq_word)));

    p_zero_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
        z_sr[2] |-> (out_i == '0) && (out_q == '0));

    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == v_sr[2]);

    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_i) && $stable(out_q));
endmodule

bind quad_lo_mixer lo_mix_checker #(
    .DATA_W  (DATA_W),
    .PHASE_W (PHASE_W)
) u_lo_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_i      (in_i),
    .in_q      (in_q),
    .freq_word (freq_word),
    .phase     (u_acc.acc_q.phase),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q)
);

// File: tb/quad_lo_mixer_test.sv
module quad_lo_mixer_test;
    localparam real TWO_PI = 2.0 * 3.14159265358979323846;
    localparam int  NVEC   = 10;

    // {in_i, in_q, freq_word, lo_phase_adj, lo_gain}
    localparam logic [75:0] VEC [NVEC] = '{
        {16'h03E8, 16'h0000, 24'h010000, 8'h00, 12'h800},
        {16'h4000, 16'h2000, 24'h200000, 8'h00, 12'h800},
        {16'hEC78, 16'h1B58, 24'h400000, 8'h00, 12'h800},
        {16'h2EE0, 16'hF448, 24'h123456, 8'h05, 12'h800},
        {16'h1000, 16'h1000, 24'h0ABCDE, 8'hF9, 12'h866},
        {16'h7FFF, 16'h7FFF, 24'h200000, 8'h00, 12'hFFF},
        {16'h0BB8, 16'h0FA0, 24'h0F0000, 8'h00, 12'h000},
        {16'h8000, 16'h8000, 24'hFFFFFF, 8'h40, 12'h400},
        {16'h1234, 16'hEDCB, 24'h765432, 8'h80, 12'hBB8},
        {16'h0000, 16'h0000, 24'h000001, 8'h00, 12'h800}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_i = '0;
    logic signed [15:0] in_q = '0;
    logic [23:0]        freq_word = '0;
    logic signed [7:0]  lo_phase_adj = '0;
    logic [11:0]        lo_gain = 12'h800;
    logic               out_valid;
    logic signed [15:0] out_i;
    logic signed [15:0] out_q;

    int checks = 0;
    int fails  = 0;
    int mphase = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    quad_lo_mixer uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_i         (in_i),
        .in_q         (in_q),
        .freq_word    (freq_word),
        .lo_phase_adj (lo_phase_adj),
        .lo_gain      (lo_gain),
        .out_valid    (out_valid),
        .out_i        (out_i),
        .out_q        (out_q)
    );

    function automatic int cosv(input int k);
        real v;
        v = $cos(TWO_PI * real'(k) / real'(256)) * real'(2047);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return $rtoi(v - 0.5);
    endfunction

    function automatic int satv(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    // Expected result per R2..R6 for table address a.
    function automatic void model(input int i, input int q, input int a, input int off,
                                  input int g, output int oi, output int oq);
        int c, s, sc;
        longint ai, aq;
        c  = cosv(a);
        s  = cosv((a + off - 64) & 255);
        sc = (s * g + 1024) >>> 11;
        ai = longint'(i) * c + longint'(q) * sc;
        aq = longint'(q) * c - longint'(i) * sc;
        oi = satv((ai + 1024) >>> 11);
        oq = satv((aq + 1024) >>> 11);
    endfunction

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Drive one sample at a negedge; returns expected outputs and advances model phase.
    task automatic drive(input int i, input int q, input int f, input int off, input int g,
                         output int ei, output int eq);
        in_valid     = 1'b1;
        in_i         = 16'(i);
        in_q         = 16'(q);
        freq_word    = 24'(f);
        lo_phase_adj = 8'(off);
        lo_gain      = 12'(g);
        model(i, q, (mphase >> 16) & 255, off, g, ei, eq);
        mphase = (mphase + f) & 32'hFFFFFF;
    endtask

    task automatic send(input int i, input int q, input int f, input int off, input int g,
                        input string tag);
        int ei, eq;
        @(negedge clk);
        drive(i, q, f, off, g, ei, eq);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk({tag, " R7 out_valid"}, int'(out_valid), 1);
        chk({tag, " out_i"}, int'(out_i), ei);
        chk({tag, " out_q"}, int'(out_q), eq);
        @(negedge clk);
        chk({tag, " R8 out_valid low"}, int'(out_valid), 0);
        chk({tag, " R8 out_i held"}, int'(out_i), ei);
        chk({tag, " R8 out_q held"}, int'(out_q), eq);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        chk("R9 out_valid in reset", int'(out_valid), 0);
        chk("R9 out_i in reset", int'(out_i), 0);
        chk("R9 out_q in reset", int'(out_q), 0);
        rst_n  = 1'b1;
        mphase = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int exp_i [8];
        int exp_q [8];
        int ei, eq;

        repeat (3) @(posedge clk);
        do_reset();

        // Table-driven: R1 R2 R3 R4 R5 R6 across varied settings.
        for (int n = 0; n < NVEC; n++) begin
            send(int'($signed(VEC[n][75:60])), int'($signed(VEC[n][59:44])),
                 int'(VEC[n][43:20]), int'($signed(VEC[n][19:12])), int'(VEC[n][11:0]),
                 $sformatf("R1/R2/R3/R4/R5 vec%0d", n));
        end

        // R7: eight samples back to back.
        for (int n = 0; n < 11; n++) begin
            @(negedge clk);
            if (n >= 3) begin
                chk($sformatf("R7 stream valid %0d", n - 3), int'(out_valid), 1);
                chk($sformatf("R5 stream i %0d", n - 3), int'(out_i), exp_i[n - 3]);
                chk($sformatf("R5 stream q %0d", n - 3), int'(out_q), exp_q[n - 3]);
            end
            if (n < 8) begin
                drive(1500 * n - 9000, 7000 - 900 * n, 24'h031000, 3, 2100, ei, eq);
                exp_i[n] = ei;
                exp_q[n] = eq;
            end else begin
                in_valid = 1'b0;
            end
        end

        // R1: idle cycles leave the phase untouched.
        repeat (7) @(negedge clk);
        send(9000, -4000, 24'h050000, 0, 2048, "R1 after idle");

        // R10: settings changed right after capture.
        @(negedge clk);
        drive(6000, 2500, 24'h2A0000, 10, 1500, ei, eq);
        @(negedge clk);
        in_valid     = 1'b0;
        lo_gain      = 12'd4000;
        lo_phase_adj = -8'sd50;
        freq_word    = 24'h777777;
        @(negedge clk);
        @(negedge clk);
        chk("R10 out_valid", int'(out_valid), 1);
        chk("R10 out_i", int'(out_i), ei);
        chk("R10 out_q", int'(out_q), eq);
        send(-7000, 3000, 24'h010000, 0, 2048, "R10 next phase");

        // R9: reset mid-run returns the phase to zero; R6 clipping at a known phase.
        do_reset();
        send(32767, 32767, 0, 32, 4095, "R6 positive clip");
        chk("R6 literal out_i", int'(out_i), 32767);
        send(-32768, -32768, 0, 32, 4095, "R6 negative clip");
        chk("R6 literal out_i", int'(out_i), -32768);
        send(20000, 0, 0, 0, 2048, "R9 phase zero");
        chk("R9 literal out_q", int'(out_q), 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule